// File: doc/BRIEF.md
# I2S Master Audio Receiver

This block is the receive side of a serial audio port acting as clock master. It divides the system clock down to a bit clock, drives the word-select line that marks left and right channels, and shifts in the serial data line. The received audio goes to the host as 16-bit packets through a small register-style interface: one strobe for reading the data word and one for reading the status.

The host selects one of four framing standards, a data width of 16, 24 or 32 bits, and a channel width of 16 or 32 bits. A sample wider than 16 bits is split into two packets, with the most significant half first. Each packet carries a tag that shows which channel it came from. The status outputs are buffer-not-empty, channel side, overrun and busy. Two interrupt outputs are gated by their own enables.

Clearing the enable does not cut a frame off partway through. The receiver completes the channel slot it is in, then parks the bit clock low and drops busy.

Top module: `i2s_rx_master`

## Requirements
- R1: The bit clock period is DIV system clocks with a 50% duty cycle. The bit clock runs only while busy is high and is held low when the receiver is idle.
- R2: Word select changes only on falling bit-clock edges. The standard is set by `std_sel`: 00 is Philips, where word select leads the first data bit by one slot and is low for the left channel. 01 is MSB-justified and 10 is LSB-justified; in both, word select is low for the whole left channel slot. 11 is PCM, where word select pulses high during the last bit slot of each channel.
- R3: Data is sampled on rising bit-clock edges, MSB first. `dlen_sel` selects the data width: 00 is 16 bits, 01 is 24 bits, 10 is 32 bits. The channel is 32 slots when `ch32_sel`=1 or when `dlen_sel`≠00, and 16 slots otherwise. Valid bits fill the first slots of the channel in standards 00, 01 and 11, and the last slots in standard 10. All other slots are ignored.
- R4: The first packet of a sample holds its top 16 bits. For 32-bit data the second packet holds the low 16 bits. For 24-bit data the second packet holds the low 8 bits in its upper byte and zeros in its lower byte.
- R5: Buffer-not-empty is set when a packet is stored and cleared by a `rd_dat` pulse. If a store and a read happen in the same cycle, the store wins.
- R6: Each stored packet updates the side flag: 0 for the left channel, 1 for the right.
- R7: A packet that completes while buffer-not-empty is set and no read is happening raises overrun and is dropped. While overrun is set, every new packet is dropped and the data output holds its value.
- R8: Overrun clears only on a `rd_stat` pulse that comes after a `rd_dat` pulse made while overrun was set.
- R9: `irq_rx_o` is buffer-not-empty gated by `ie_rx`. `irq_err_o` is overrun gated by `ie_err`.
- R10: After `en` falls, the receiver finishes the current channel slot and then stops. Busy falls on the last falling edge of that slot, and the bit clock stays low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable |
| std_sel | input | 2 | Framing standard |
| dlen_sel | input | 2 | Data width code |
| ch32_sel | input | 1 | Request a 32-slot channel for 16-bit data |
| ie_rx | input | 1 | Buffer-not-empty interrupt enable |
| ie_err | input | 1 | Overrun interrupt enable |
| rd_dat | input | 1 | Host data-register read strobe |
| rd_stat | input | 1 | Host status-register read strobe |
| sd_in | input | 1 | Serial audio data |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| rx_data | output | 16 | Received packet |
| ne_o | output | 1 | Buffer not empty |
| side_o | output | 1 | Channel of the stored packet |
| ovr_o | output | 1 | Overrun |
| busy_o | output | 1 | Receiver running |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The assertions assume the following about the inputs:
- `rd_dat` and `rd_stat` are single-cycle strobes.
- `sd_in` changes only after a falling bit-clock edge, so it is stable on the rising edge that samples it.

The bench drives the data line one time unit after each falling edge of `bclk_o` and raises each strobe for exactly one system clock. It changes the configuration only while busy is low. Each configuration is fixed at start-up anyway, so a mid-frame change would not be seen.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;
  localparam int PKT_W = 16;

  localparam logic [1:0] STD_PHIL = 2'b00;
  localparam logic [1:0] STD_MSBJ = 2'b01;
  localparam logic [1:0] STD_LSBJ = 2'b10;
  localparam logic [1:0] STD_PCM  = 2'b11;

  // sample width from the data-length code
  function automatic logic [5:0] data_bits(logic [1:0] code);
    case (code)
      2'b00:   return 6'd16;
      2'b01:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // wide data always forces a 32-slot channel
  function automatic logic wide_chan(logic req32, logic [1:0] code);
    return req32 | (code != 2'b00);
  endfunction
endpackage

// File: rtl/i2srx_clkgen.sv
module i2srx_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk,
  output logic rise_p,
  output logic fall_p
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_q, bclk_d;
  logic          tick;

  assign tick   = run && (cnt_q == CW'(HALF - 1));
  assign rise_p = tick && !bclk_q;
  assign fall_p = tick && bclk_q;
  assign bclk   = bclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!run) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      bclk_d = !bclk_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  // R1: once the framer stops, the bit clock parks low
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bclk_q);
endmodule

// File: rtl/i2srx_framer.sv
module i2srx_framer
  import i2srx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       std_i,
  input  logic [1:0]       dl_i,
  input  logic             c32_i,
  input  logic             sd,
  input  logic             rise_p,
  input  logic             fall_p,
  output logic             run,
  output logic             ws,
  output logic             pkt_v,
  output logic [PKT_W-1:0] pkt_data,
  output logic             pkt_side
);
  logic             run_q, run_d, ws_q, ws_d, c32_q, c32_d;
  logic [5:0]       c_q, c_d;
  logic [1:0]       std_q, std_d, dl_q, dl_d;
  logic [PKT_W-1:0] sh_q, sh_d;

  logic [5:0] ch, last_c, c_nxt, p, dbits, off, v;
  logic       side, chan_end, valid, pkt_end;

  function automatic logic ws_of(logic [5:0] cc, logic w32, logic [1:0] st);
    logic [5:0] lc, nc, pp;
    lc = w32 ? 6'd63 : 6'd31;
    nc = (cc == lc) ? 6'd0 : cc + 6'd1;
    pp = w32 ? {1'b0, cc[4:0]} : {2'b00, cc[3:0]};
    case (st)
      STD_PHIL: return w32 ? nc[5] : nc[4];
      STD_PCM:  return pp == (w32 ? 6'd31 : 6'd15);
      default:  return w32 ? cc[5] : cc[4];
    endcase
  endfunction

  // slot decode
  always_comb begin
    ch       = c32_q ? 6'd32 : 6'd16;
    last_c   = c32_q ? 6'd63 : 6'd31;
    c_nxt    = (c_q == last_c) ? 6'd0 : c_q + 6'd1;
    p        = c32_q ? {1'b0, c_q[4:0]} : {2'b00, c_q[3:0]};
    side     = c32_q ? c_q[5] : c_q[4];
    chan_end = (p == ch - 6'd1);
    dbits    = data_bits(dl_q);
    off      = (std_q == STD_LSBJ) ? (ch - dbits) : 6'd0;
    valid    = (p >= off) && (p < off + dbits);
    v        = p - off;
    pkt_end  = (v[3:0] == 4'hF) || (v == dbits - 6'd1);
  end

  // next state
  always_comb begin
    run_d = run_q;
    c_d   = c_q;
    ws_d  = ws_q;
    std_d = std_q;
    dl_d  = dl_q;
    c32_d = c32_q;
    sh_d  = sh_q;
    if (!run_q) begin
      if (en) begin
        run_d = 1'b1;
        c_d   = 6'd0;
        std_d = std_i;
        dl_d  = dl_i;
        c32_d = wide_chan(c32_i, dl_i);
        ws_d  = ws_of(6'd0, wide_chan(c32_i, dl_i), std_i);
      end
    end else begin
      if (rise_p && valid)
        sh_d = (v[3:0] == 4'h0) ? {{(PKT_W-1){1'b0}}, sd} : {sh_q[PKT_W-2:0], sd};
      if (fall_p) begin
        if (chan_end && !en) begin
          run_d = 1'b0;
          c_d   = 6'd0;
          ws_d  = 1'b0;
        end else begin
          c_d  = c_nxt;
          ws_d = ws_of(c_nxt, c32_q, std_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      c_q   <= '0;
      ws_q  <= 1'b0;
      std_q <= '0;
      dl_q  <= '0;
      c32_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      run_q <= run_d;
      c_q   <= c_d;
      ws_q  <= ws_d;
      std_q <= std_d;
      dl_q  <= dl_d;
      c32_q <= c32_d;
      sh_q  <= sh_d;
    end
  end

  assign run      = run_q;
  assign ws       = ws_q;
  assign pkt_v    = run_q && rise_p && valid && pkt_end;
  assign pkt_data = sh_d << (4'd15 - v[3:0]);
  assign pkt_side = side;

  // R2: word select moves only after a falling bit-clock edge
  a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(fall_p)) |-> $stable(ws_q));

  // R10: the receiver never stops while still enabled
  a_r10_stop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !$past(en));
endmodule

// File: rtl/i2srx_flags.sv
module i2srx_flags
  import i2srx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_v,
  input  logic [PKT_W-1:0] pkt_data,
  input  logic             pkt_side,
  input  logic             rd_dat,
  input  logic             rd_stat,
  output logic [PKT_W-1:0] data,
  output logic             ne,
  output logic             side,
  output logic             ovr
);
  logic [PKT_W-1:0] data_q, data_d;
  logic ne_q, ne_d, side_q, side_d, ovr_q, ovr_d, arm_q, arm_d;
  logic take, lose;

  always_comb begin
    take   = pkt_v && !ovr_q && (!ne_q || rd_dat);
    lose   = pkt_v && !ovr_q && ne_q && !rd_dat;
    data_d = take ? pkt_data : data_q;
    side_d = take ? pkt_side : side_q;
    ne_d   = take ? 1'b1 : (rd_dat ? 1'b0 : ne_q);
    arm_d  = !ovr_q ? 1'b0 : (rd_dat ? 1'b1 : arm_q);
    if (lose)
      ovr_d = 1'b1;
    else if (ovr_q && arm_q && rd_stat)
      ovr_d = 1'b0;
    else
      ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ne_q   <= 1'b0;
      side_q <= 1'b0;
      ovr_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      ne_q   <= ne_d;
      side_q <= side_d;
      ovr_q  <= ovr_d;
      arm_q  <= arm_d;
    end
  end

  assign data = data_q;
  assign ne   = ne_q;
  assign side = side_q;
  assign ovr  = ovr_q;

  // R5: a packet from the framer always leaves the buffer full
  a_r5_ne_after_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_v && !ovr_q) |=> ne_q);

  // R7: unread data is never overwritten
  a_r7_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (ne_q && !rd_dat) |=> $stable(data_q));

  // R8: overrun is sticky until a status read
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !rd_stat) |=> ovr_q);
endmodule

// File: rtl/i2s_rx_master.sv
module i2s_rx_master
  import i2srx_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  std_sel,
  input  logic [1:0]  dlen_sel,
  input  logic        ch32_sel,
  input  logic        ie_rx,
  input  logic        ie_err,
  input  logic        rd_dat,
  input  logic        rd_stat,
  input  logic        sd_in,
  output logic        bclk_o,
  output logic        ws_o,
  output logic [15:0] rx_data,
  output logic        ne_o,
  output logic        side_o,
  output logic        ovr_o,
  output logic        busy_o,
  output logic        irq_rx_o,
  output logic        irq_err_o
);
  logic [1:0]       rs_q;
  logic             rst_ni;
  logic             run, rise_p, fall_p, pkt_v, pkt_side;
  logic [PKT_W-1:0] pkt_data;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  i2srx_clkgen #(.DIV(DIV)) u_clk (
    .clk    (clk),
    .rst_n  (rst_ni),
    .run    (run),
    .bclk   (bclk_o),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  i2srx_framer u_frm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .en       (en),
    .std_i    (std_sel),
    .dl_i     (dlen_sel),
    .c32_i    (ch32_sel),
    .sd       (sd_in),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .run      (run),
    .ws       (ws_o),
    .pkt_v    (pkt_v),
    .pkt_data (pkt_data),
    .pkt_side (pkt_side)
  );

  i2srx_flags u_flg (
    .clk      (clk),
    .rst_n    (rst_ni),
    .pkt_v    (pkt_v),
    .pkt_data (pkt_data),
    .pkt_side (pkt_side),
    .rd_dat   (rd_dat),
    .rd_stat  (rd_stat),
    .data     (rx_data),
    .ne       (ne_o),
    .side     (side_o),
    .ovr      (ovr_o)
  );

  assign busy_o    = run;
  assign irq_rx_o  = ne_o && ie_rx;
  assign irq_err_o = ovr_o && ie_err;
endmodule

// File: tb/i2s_rx_master_test.sv
module i2s_rx_master_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n, en, ch32_sel, ie_rx, ie_err, rd_stat, sd_in;
  logic rd_dat = 1'b0;
  logic [1:0] std_sel, dlen_sel;
  logic bclk_o, ws_o, ne_o, side_o, ovr_o, busy_o, irq_rx_o, irq_err_o;
  logic [15:0] rx_data;

  int ntot = 0, nfail = 0;
  int nrise = 0, nfall = 0, j = 0;
  int cur_std = 0, cur_dl = 0, cur_c32 = 0, cur_i = 0;
  bit reading = 0, man_rd = 0;
  time last_rise = 0;

  always #4 clk = ~clk;

  i2s_rx_master #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .std_sel(std_sel), .dlen_sel(dlen_sel),
    .ch32_sel(ch32_sel), .ie_rx(ie_rx), .ie_err(ie_err), .rd_dat(rd_dat),
    .rd_stat(rd_stat), .sd_in(sd_in), .bclk_o(bclk_o), .ws_o(ws_o),
    .rx_data(rx_data), .ne_o(ne_o), .side_o(side_o), .ovr_o(ovr_o),
    .busy_o(busy_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o)
  );

  function automatic int dbits_f();
    return (cur_dl == 0) ? 16 : (cur_dl == 1) ? 24 : 32;
  endfunction
  function automatic int chb_f();
    return (cur_c32 != 0 || cur_dl != 0) ? 32 : 16;
  endfunction
  function automatic logic [31:0] word_f(int f, int ch);
    logic [31:0] m;
    m = 32'(f * 2 + ch + 1 + cur_i * 8);
    return (m * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic bit_f(int s);
    int CH, D, c, p, off;
    logic [31:0] w;
    CH = chb_f(); D = dbits_f();
    c = s % (2 * CH); p = c % CH;
    off = (cur_std == 2) ? CH - D : 0;
    w = word_f(s / (2 * CH), c / CH);
    if (p >= off && p < off + D) return w[31 - (p - off)];
    return 1'b1;
  endfunction
  function automatic int ppc_f();
    return (dbits_f() > 16) ? 2 : 1;
  endfunction
  function automatic logic [15:0] pkt_f(int jj);
    int ppc, r;
    logic [31:0] w;
    ppc = ppc_f(); r = jj % (2 * ppc);
    w = word_f(jj / (2 * ppc), r / ppc);
    if (r % ppc == 0) return w[31:16];
    if (dbits_f() == 24) return {w[15:8], 8'h00};
    return w[15:0];
  endfunction
  function automatic logic side_f(int jj);
    return ((jj % (2 * ppc_f())) / ppc_f()) != 0;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // data driver: slot index equals falls seen so far
  initial forever begin
    @(negedge bclk_o); #1;
    nfall++;
    sd_in = bit_f(nfall);
  end

  // word select and bit-clock period monitor
  initial forever begin
    int CH, c;
    logic e;
    @(posedge bclk_o); #1;
    CH = chb_f(); c = nrise % (2 * CH);
    case (cur_std)
      0:       e = (((c + 1) % (2 * CH)) >= CH);
      3:       e = ((c % CH) == CH - 1);
      default: e = (c >= CH);
    endcase
    chk(ws_o == e, "R2", "word select", 32'(ws_o), 32'(e));
    if (nrise > 0)
      chk(($time - last_rise) == DIV * 8, "R1", "bit clock period",
          32'($time - last_rise), 32'(DIV * 8));
    last_rise = $time;
    nrise++;
  end

  // host reader
  initial forever begin
    @(negedge clk);
    if (reading && ne_o) begin
      chk(rx_data == pkt_f(j), "R4", "packet data", 32'(rx_data), 32'(pkt_f(j)));
      chk(side_o == side_f(j), "R6", "channel side", 32'(side_o), 32'(side_f(j)));
      j++;
      rd_dat = 1'b1;
    end else begin
      rd_dat = man_rd;
    end
  end

  task automatic wait_rises(int n);
    int t = 0;
    while (nrise < n && t < 50000) begin @(negedge clk); t++; end
  endtask
  task automatic wait_idle();
    int t = 0;
    while (busy_o && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic run_cfg(int st, int k);
    int CH, nf0, exp_r;
    cur_std = st;
    cur_dl  = (k < 2) ? 0 : k - 1;
    cur_c32 = (k == 0) ? 0 : 1;
    cur_i   = st * 4 + k;
    CH = chb_f();
    j = 0; nrise = 0; nfall = 0;
    sd_in = bit_f(0);
    reading = 1;
    std_sel = 2'(st); dlen_sel = 2'(cur_dl); ch32_sel = 1'(cur_c32);
    @(negedge clk); en = 1'b1;
    wait_rises(4 * CH + (cur_i * 7) % (2 * CH));
    @(negedge clk); nf0 = nfall; en = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    exp_r = (nf0 / CH + 1) * CH;
    chk(nrise == exp_r, "R10", "bit count at stop", 32'(nrise), 32'(exp_r));
    chk(j == (exp_r / CH) * ppc_f(), "R3", "packets delivered", 32'(j), 32'((exp_r / CH) * ppc_f()));
    chk(!busy_o && !bclk_o && !ws_o, "R10", "idle outputs", {29'd0, busy_o, bclk_o, ws_o}, 32'd0);
    chk(!ne_o && !ovr_o, "R5", "flags after prompt reads", {30'd0, ne_o, ovr_o}, 32'd0);
  endtask

  task automatic overrun_test();
    cur_std = 0; cur_dl = 0; cur_c32 = 0; cur_i = 16;
    j = 0; nrise = 0; nfall = 0;
    sd_in = bit_f(0);
    reading = 0;
    std_sel = 2'b00; dlen_sel = 2'b00; ch32_sel = 1'b0;
    ie_rx = 1'b1; ie_err = 1'b1;
    @(negedge clk); en = 1'b1;
    wait_rises(50);
    @(negedge clk);
    chk(ne_o == 1'b1, "R5", "buffer full", 32'(ne_o), 32'd1);
    chk(ovr_o == 1'b1, "R7", "overrun raised", 32'(ovr_o), 32'd1);
    chk(rx_data == pkt_f(0), "R7", "first packet kept", 32'(rx_data), 32'(pkt_f(0)));
    chk(side_o == 1'b0, "R6", "kept packet side", 32'(side_o), 32'd0);
    chk(irq_rx_o && irq_err_o, "R9", "both interrupts", {30'd0, irq_rx_o, irq_err_o}, 32'd3);
    ie_rx = 1'b0;
    @(negedge clk);
    chk(!irq_rx_o, "R9", "receive irq masked", 32'(irq_rx_o), 32'd0);
    @(posedge clk); #1 man_rd = 1'b1;
    @(posedge clk); #1 man_rd = 1'b0;
    @(negedge clk); #1;
    chk(!ne_o, "R5", "read clears not-empty", 32'(ne_o), 32'd0);
    chk(ovr_o, "R8", "overrun survives data read", 32'(ovr_o), 32'd1);
    wait_rises(66);
    @(negedge clk);
    chk(!ne_o, "R7", "packet dropped during overrun", 32'(ne_o), 32'd0);
    rd_stat = 1'b1;
    @(negedge clk); rd_stat = 1'b0;
    chk(!ovr_o && !irq_err_o, "R8", "status read clears overrun", {30'd0, ovr_o, irq_err_o}, 32'd0);
    wait_rises(82);
    @(negedge clk);
    chk(ne_o, "R5", "reception resumes", 32'(ne_o), 32'd1);
    chk(rx_data == pkt_f(4), "R4", "resumed packet", 32'(rx_data), 32'(pkt_f(4)));
    chk(side_o == 1'b0, "R6", "resumed side", 32'(side_o), 32'd0);
    en = 1'b0;
    wait_idle();
    @(negedge clk);
    chk(!busy_o, "R10", "stopped after overrun test", 32'(busy_o), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    ntot++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; rd_stat = 1'b0; sd_in = 1'b0;
    std_sel = 2'b00; dlen_sel = 2'b00; ch32_sel = 1'b0;
    ie_rx = 1'b1; ie_err = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !bclk_o && !ws_o, "R1", "reset clock outputs", {29'd0, busy_o, bclk_o, ws_o}, 32'd0);
    chk(!ne_o && !ovr_o && !side_o, "R5", "reset flags", {29'd0, ne_o, ovr_o, side_o}, 32'd0);
    chk(!irq_rx_o && !irq_err_o, "R9", "reset interrupts", {30'd0, irq_rx_o, irq_err_o}, 32'd0);
    for (int st = 0; st < 4; st++)
      for (int k = 0; k < 4; k++)
        run_cfg(st, k);
    overrun_test();
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule